// File: doc/BRIEF.md
# Dual-channel prescaled PWM controller

This block is a small register-mapped pulse-width modulator with two output channels. Software programs it over a simple synchronous word-addressed read/write bus. One shared control word holds a seven-bit field per channel, at a stride of fifteen bits: a four-bit clock-divider code, an enable, an active-level select and a clock gate. The same word also carries one read-only pending flag per channel. Each channel also has its own timing word. The high half holds the period length minus one and the low half holds the active (duty) count.

Each channel slows the input clock through a fixed lookup of divide ratios, or uses the clock directly when it is given the bypass code. It then runs a period counter from zero up to the programmed period field. The output is at the active level while the count is below the duty field. A timing write to a running channel is held in a shadow copy and raises the pending flag. It takes effect at the end of the current period, so the waveform never shows a torn period. Writes that arrive while the flag is up are dropped.

Each channel is driven by a three-state machine. CH_OFF is the disabled state: counters are cleared and the output is inactive. CH_HOLD is enabled but stalled, because the clock gate is clear or the divider code is unused; the counters are frozen. CH_RUN is counting. The transitions are T_START (CH_OFF to CH_RUN), T_ARM (CH_OFF to CH_HOLD), T_STALL (CH_RUN to CH_HOLD), T_RESUME (CH_HOLD to CH_RUN) and T_STOP (CH_RUN or CH_HOLD to CH_OFF). A channel leaves CH_OFF when its enable bit is set. It is in CH_RUN exactly while the enable and gate bits are set and the code is valid. The state register follows the control word one clock later.

Top module: `dual_pwm_unit`

## Requirements
- R1: After reset the control word and both timing words read 0, and both outputs are high. An active-level bit of 0 means inverted, so the inactive level is high.
- R2: Word address 0 is the control word. Word address 1+n is the timing word of channel n. Channel n's field sits at control bits [15n+6:15n]: [3:0] divider code, [4] enable, [5] active level, [6] clock gate. The pending flag of channel n reads at bit 28+n. All other control bits read 0 and are ignored on write.
- R3: Divider codes 0,1,2,3,4 make each count last 120,180,240,360,480 clocks. Codes 8,9,10,11,12 make it last 12000,24000,36000,48000,72000 clocks.
- R4: Divider code 15 bypasses the divider, so the period counter advances on every clock.
- R5: With timing word {P[31:16], D[15:0]}, the waveform repeats every P+1 counts and is active for the first D of them. D=0 gives a constant inactive output. D>P gives a constant active output.
- R6: Active-level bit 1 drives high during the active part. Bit 0 inverts the output.
- R7: A channel counts only while its enable and gate bits are set and its code is valid. Clearing the gate, or selecting an unused code (5-7, 13, 14), freezes the output where it stands.
- R8: A disabled channel holds its output at the inactive level and resets its counters.
- R9: A timing write to an enabled channel goes to a shadow copy and sets the pending flag. The shadow value is applied when the current period ends, and the flag clears at that moment. Reading a timing word returns the last accepted value.
- R10: While a channel's pending flag is set, timing writes to that channel are ignored.
- R11: A timing write to a disabled channel is applied at once and leaves the pending flag clear. Disabling a channel while its flag is set applies the shadow value and clears the flag.
- R12: The two channels run independently, each with its own field, timing word and waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (2) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe, else 0 |
| pwm_out | output | NCH (2) | One waveform output per channel |

## Verification
A corrupted counter or divider shows up at once as a wrong ratio of active cycles. The bench counts these over a window of whole periods, so any error in period length, duty compare or divide ratio changes the count within two periods. A stuck state machine shows up in different ways. If it is stuck in CH_RUN, the output keeps toggling where it should freeze. If it is stuck in CH_HOLD or CH_OFF, the output stays constant where it should toggle. Either is visible a few clocks after the control write. A wrong pending flag is visible at once, in the control readback and in the timing-word readback just after a second write. It shows later as a waveform that does or does not take the new timing at the next period end.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int REG_W        = 32;
    localparam int FIELD_STRIDE = 15;
    localparam int CFG_W        = 7;
    localparam int READY_BASE   = 28;
    localparam int CNT_W        = 16;
    localparam int DIV_W        = 17;

    localparam logic [3:0] CODE_BYPASS = 4'hF;

    // Channel field as laid out in the control word (gate is the top bit).
    typedef struct packed {
        logic       gate;
        logic       act;
        logic       en;
        logic [3:0] code;
    } ch_cfg_t;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_HOLD = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_t;

    // Clocks per count for each divider code; 0 marks an unused code.
    function automatic logic [DIV_W-1:0] code_ratio(input logic [3:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            4'd0:        r = DIV_W'(120);
            4'd1:        r = DIV_W'(180);
            4'd2:        r = DIV_W'(240);
            4'd3:        r = DIV_W'(360);
            4'd4:        r = DIV_W'(480);
            4'd8:        r = DIV_W'(12000);
            4'd9:        r = DIV_W'(24000);
            4'd10:       r = DIV_W'(36000);
            4'd11:       r = DIV_W'(48000);
            4'd12:       r = DIV_W'(72000);
            CODE_BYPASS: r = DIV_W'(1);
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
    import dpwm_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_en,
    input  logic                        bus_we,
    input  logic [AW-1:0]               bus_addr,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [NCH-1:0]              wrap,
    output ch_cfg_t [NCH-1:0]           cfg_q,
    output logic [NCH-1:0][REG_W-1:0]   shadow_q,
    output logic [NCH-1:0][REG_W-1:0]   timing_q,
    output logic [NCH-1:0]              pend_q
);

    logic            wr_ctrl;
    logic [NCH-1:0]  wr_tim;
    logic            rd_strobe;

    always_comb begin
        wr_ctrl   = bus_en && bus_we && (bus_addr == '0);
        rd_strobe = bus_en && !bus_we;
        for (int i = 0; i < NCH; i++) begin
            wr_tim[i] = bus_en && bus_we && (bus_addr == AW'(i + 1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            shadow_q <= '0;
            timing_q <= '0;
            pend_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                for (int i = 0; i < NCH; i++) begin
                    cfg_q[i] <= ch_cfg_t'(bus_wdata[i*FIELD_STRIDE +: CFG_W]);
                end
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_tim[i] && !pend_q[i]) begin
                    shadow_q[i] <= bus_wdata;
                    if (cfg_q[i].en) begin
                        pend_q[i] <= 1'b1;
                    end else begin
                        timing_q[i] <= bus_wdata;
                    end
                end else if (pend_q[i] && (wrap[i] || !cfg_q[i].en)) begin
                    timing_q[i] <= shadow_q[i];
                    pend_q[i]   <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_strobe) begin
            if (bus_addr == '0) begin
                for (int i = 0; i < NCH; i++) begin
                    bus_rdata[i*FIELD_STRIDE +: CFG_W] = cfg_q[i];
                    bus_rdata[READY_BASE + i]          = pend_q[i];
                end
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr == AW'(i + 1)) begin
                        bus_rdata = shadow_q[i];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler
    import dpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] code,
    input  logic       clear,
    input  logic       advance,
    output logic       code_ok,
    output logic       tick
);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] div_cnt;

    always_comb begin
        ratio   = code_ratio(code);
        code_ok = (ratio != '0);
        // >= keeps a shrinking ratio from running the counter past its end
        tick    = advance && code_ok && (div_cnt >= ratio - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            div_cnt <= '0;
        end else if (advance) begin
            div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          act,
    input  logic          gate,
    input  logic          code_ok,
    input  logic          tick,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] duty,
    output ch_state_t     state,
    output logic          advance,
    output logic          clear,
    output logic          wrap,
    output logic [CW-1:0] cnt,
    output logic          pwm_out
);

    ch_state_t state_q;
    ch_state_t state_d;
    logic      can_run;
    logic      level;

    assign can_run = gate && code_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (en) begin
                    state_d = can_run ? CH_RUN : CH_HOLD;   // T_START / T_ARM
                end
            end
            CH_HOLD: begin
                if (!en) begin
                    state_d = CH_OFF;                        // T_STOP
                end else if (can_run) begin
                    state_d = CH_RUN;                        // T_RESUME
                end
            end
            CH_RUN: begin
                if (!en) begin
                    state_d = CH_OFF;                        // T_STOP
                end else if (!can_run) begin
                    state_d = CH_HOLD;                       // T_STALL
                end
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q == CH_OFF) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt >= period) ? '0 : cnt + CW'(1);
        end
    end

    always_comb begin
        state   = state_q;
        advance = (state_q == CH_RUN);
        clear   = (state_q == CH_OFF);
        wrap    = tick && (cnt >= period);
        level   = (state_q != CH_OFF) && (cnt < duty);
        pwm_out = act ? level : !level;
    end

endmodule

// File: rtl/dual_pwm_unit.sv
module dual_pwm_unit
    import dpwm_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [NCH-1:0]   pwm_out
);

    ch_cfg_t   [NCH-1:0]            cfg;
    logic      [NCH-1:0][REG_W-1:0] shadow;
    logic      [NCH-1:0][REG_W-1:0] timing;
    logic      [NCH-1:0]            pend;
    logic      [NCH-1:0]            wrap;
    logic      [NCH-1:0]            ch_en;
    logic      [NCH-1:0]            ch_act;
    logic      [NCH-1:0]            ch_gate;
    logic      [NCH-1:0][CNT_W-1:0] ch_period;
    logic      [NCH-1:0][CNT_W-1:0] ch_duty;
    logic      [NCH-1:0][CNT_W-1:0] cnt;
    ch_state_t [NCH-1:0]            state;

    dpwm_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wrap      (wrap),
        .cfg_q     (cfg),
        .shadow_q  (shadow),
        .timing_q  (timing),
        .pend_q    (pend)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic tick;
        logic code_ok;
        logic advance;
        logic clear;

        assign ch_en[g]     = cfg[g].en;
        assign ch_act[g]    = cfg[g].act;
        assign ch_gate[g]   = cfg[g].gate;
        assign ch_period[g] = timing[g][REG_W-1:CNT_W];
        assign ch_duty[g]   = timing[g][CNT_W-1:0];

        dpwm_prescaler u_psc (
            .clk     (clk),
            .rst_n   (rst_n),
            .code    (cfg[g].code),
            .clear   (clear),
            .advance (advance),
            .code_ok (code_ok),
            .tick    (tick)
        );

        dpwm_channel #(.CW(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ch_en[g]),
            .act     (ch_act[g]),
            .gate    (ch_gate[g]),
            .code_ok (code_ok),
            .tick    (tick),
            .period  (ch_period[g]),
            .duty    (ch_duty[g]),
            .state   (state[g]),
            .advance (advance),
            .clear   (clear),
            .wrap    (wrap[g]),
            .cnt     (cnt[g]),
            .pwm_out (pwm_out[g])
        );
    end

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
    import dpwm_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_en,
    input logic                        bus_we,
    input logic [AW-1:0]               bus_addr,
    input logic [NCH-1:0]              ch_en,
    input logic [NCH-1:0]              ch_act,
    input logic [NCH-1:0]              pend,
    input logic [NCH-1:0]              wrap,
    input logic [NCH-1:0][REG_W-1:0]   shadow,
    input logic [NCH-1:0][CNT_W-1:0]   ch_period,
    input logic [NCH-1:0][CNT_W-1:0]   cnt,
    input ch_state_t [NCH-1:0]         state,
    input logic [NCH-1:0]              pwm_out
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(ch_en[g]) |-> (pwm_out[g] == !ch_act[g])); // R8

        AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_en && bus_we && bus_addr == AW'(g + 1) && pend[g]) |=> $stable(shadow[g])); // R10

        AST_READY_CLEARS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[g] && wrap[g]) |=> !pend[g]); // R9

        AST_NO_READY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[g] |=> !pend[g]); // R11

        AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (state[g] != CH_OFF) |-> (cnt[g] <= ch_period[g])); // R5

        AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (state[g] == CH_HOLD) |=> $stable(cnt[g])); // R7
    end

endmodule

bind dual_pwm_unit dpwm_checker #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .ch_en     (ch_en),
    .ch_act    (ch_act),
    .pend      (pend),
    .wrap      (wrap),
    .shadow    (shadow),
    .ch_period (ch_period),
    .cnt       (cnt),
    .state     (state),
    .pwm_out   (pwm_out)
);

// File: tb/dual_pwm_unit_bench.sv
module dual_pwm_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int AW  = 2;

    // Vector table: divider code, period field, duty field, active level,
    // window (two whole periods in clocks), expected active-high cycles.
    localparam int NV = 8;
    localparam int V_CODE[NV] = '{15, 15, 15, 15, 15,   0,   1, 15};
    localparam int V_PER [NV] = '{ 3,  3,  4,  2,  3,   3,   1,  0};
    localparam int V_DUTY[NV] = '{ 1,  2,  0,  5,  1,   1,   1,  1};
    localparam int V_ACT [NV] = '{ 1,  1,  1,  1,  0,   1,   1,  1};
    localparam int V_WIN [NV] = '{ 8,  8, 10,  6,  8, 960, 720,  2};
    localparam int V_HI  [NV] = '{ 2,  4,  0,  6,  6, 240, 360,  2};
    // rows: R4 R5 basic, R5 half duty, R5 zero duty, R5 duty>period,
    // R6 inverted, R3 code 0, R3 code 1, R5 single-count period

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_en = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pwm_unit #(.NCH(NCH), .AW(AW)) u_dual_pwm_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the following posedge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    // Combinational read sampled inside the low phase.
    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic count_high(input int ch, input int win, output int hi);
        hi = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic count_changes(input int ch, input int win, output int n);
        logic prev;
        n = 0;
        prev = pwm_out[ch];
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (pwm_out[ch] !== prev) n++;
            prev = pwm_out[ch];
        end
    endtask

    function automatic logic [31:0] fld(input logic [3:0] c, input logic e, input logic a, input logic g);
        return {25'd0, g, a, e, c};
    endfunction

    function automatic logic [31:0] ctl(input logic [31:0] f0, input logic [31:0] f1);
        return f0 | (f1 << 15);
    endfunction

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        int hi;
        int hi1;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs after reset", 32'(pwm_out), 32'h3);
        rd(2'd0, d); check("R1 control after reset", d, 32'h0);
        rd(2'd1, d); check("R1 timing0 after reset", d, 32'h0);
        rd(2'd2, d); check("R1 timing1 after reset", d, 32'h0);

        // Table walk over channel 0: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 32'h0);
            wr(2'd1, {16'(V_PER[i]), 16'(V_DUTY[i])});
            wr(2'd0, fld(4'(V_CODE[i]), 1'b1, 1'(V_ACT[i]), 1'b1));
            settle(4);
            count_high(0, V_WIN[i], hi);
            check($sformatf("R3 R4 R5 R6 vector %0d", i), 32'(hi), 32'(V_HI[i]));
        end

        // R12 and R2: both channels at once, field stride and readback mask
        wr(2'd0, 32'h0);
        wr(2'd1, {16'd3, 16'd1});
        wr(2'd2, {16'd1, 16'd1});
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R2 control readback mask", d, 32'h003F_807F);
        wr(2'd0, ctl(fld(4'd15, 1'b1, 1'b1, 1'b1), fld(4'd15, 1'b1, 1'b1, 1'b1)));
        settle(4);
        fork
            count_high(0, 8, hi);
            count_high(1, 8, hi1);
        join
        check("R12 channel 0 duty", 32'(hi), 32'd2);
        check("R12 channel 1 duty", 32'(hi1), 32'd4);

        // R9 R10: shadow write while running
        wr(2'd1, {16'd3, 16'd2});
        rd(2'd0, d);
        check("R9 pending flag set", 32'(d[28]), 32'd1);
        check("R2 channel 1 flag clear", 32'(d[29]), 32'd0);
        wr(2'd1, {16'd1, 16'd1});
        rd(2'd1, d); check("R10 blocked write ignored", d, {16'd3, 16'd2});
        settle(12);
        rd(2'd0, d); check("R9 flag clears at period end", 32'(d[28]), 32'd0);
        count_high(0, 8, hi);
        check("R9 new duty applied", 32'(hi), 32'd4);

        // R7: unused code and clear gate both freeze the output
        wr(2'd0, ctl(fld(4'd5, 1'b1, 1'b1, 1'b1), fld(4'd15, 1'b1, 1'b1, 1'b1)));
        settle(3);
        count_changes(0, 40, n);
        check("R7 unused code freezes", 32'(n), 32'd0);
        wr(2'd0, ctl(fld(4'd15, 1'b1, 1'b1, 1'b0), fld(4'd15, 1'b1, 1'b1, 1'b1)));
        settle(3);
        count_changes(0, 40, n);
        check("R7 gate clear freezes", 32'(n), 32'd0);
        wr(2'd0, ctl(fld(4'd15, 1'b1, 1'b1, 1'b1), fld(4'd15, 1'b1, 1'b1, 1'b1)));
        settle(3);
        count_high(0, 8, hi);
        check("R7 resumes counting", 32'(hi), 32'd4);

        // R8 R6: disabled output sits at the inactive level
        wr(2'd0, fld(4'd15, 1'b0, 1'b1, 1'b1));
        settle(3);
        count_high(0, 20, hi);
        check("R8 disabled active-high output low", 32'(hi), 32'd0);
        wr(2'd0, fld(4'd15, 1'b0, 1'b0, 1'b1));
        settle(3);
        count_high(0, 20, hi);
        check("R8 R6 disabled inverted output high", 32'(hi), 32'd20);

        // R11: write while disabled applies at once
        wr(2'd1, {16'd4, 16'd1});
        rd(2'd0, d); check("R11 no flag when disabled", 32'(d[28]), 32'd0);
        rd(2'd1, d); check("R11 timing readback", d, {16'd4, 16'd1});
        wr(2'd0, fld(4'd15, 1'b1, 1'b1, 1'b1));
        settle(4);
        count_high(0, 10, hi);
        check("R11 immediate timing used", 32'(hi), 32'd2);

        // R11: pending value applied on disable
        wr(2'd0, 32'h0);
        wr(2'd1, {16'd999, 16'd1});
        wr(2'd0, fld(4'd15, 1'b1, 1'b1, 1'b1));
        settle(4);
        wr(2'd1, {16'd3, 16'd3});
        rd(2'd0, d); check("R9 flag set on long period", 32'(d[28]), 32'd1);
        wr(2'd0, fld(4'd15, 1'b0, 1'b1, 1'b1));
        settle(2);
        rd(2'd0, d); check("R11 disable clears flag", 32'(d[28]), 32'd0);
        wr(2'd0, fld(4'd15, 1'b1, 1'b1, 1'b1));
        settle(4);
        count_high(0, 8, hi);
        check("R11 pending value applied", 32'(hi), 32'd6);

        done = 1'b1;
        report();
    end

endmodule